// File: doc/BRIEF.md
# Search Master for a Distributed Finite-Domain Solver

This block is the master-side sequencer of a constraint search that runs across several processing nodes. Each node runs propagation on its own slice of the variable store. When every node has gone quiet, the controller starts a labelling step. It broadcasts a checkpoint order and waits until every node has confirmed it. It then tells the node that owns the next unbound variable to fix that variable to a candidate value, and lets propagation run again.

If any node reports a contradiction, the controller stops the whole network and rolls every node back to its last checkpoint. It then tries the next candidate value for the same variable. When a variable has no candidates left, it rolls back one more level. The search ends with a held "solved" or "unsolvable" verdict. Variables are labelled in index order, candidates are tried in ascending order, and variable `v` lives on node `v mod N_NODES`.

Top module: `solver_dist_ctrl`

## Requirements
- R1: A labelling step from the propagation phase begins only after the network has been quiet on two consecutive sampled edges while propagating. Quiet means every `node_idle` bit is 1 and `upd_busy` is 0.
- R2: The controller waits for a barrier after each checkpoint order and after each rollback order. It issues no further order, and does not finish, until every node has pulsed `node_ack` at least once since that order.
- R3: Command opcodes are 0 checkpoint, 1 bind, 2 rollback, 3 halt and 4 resume. A labelling step is always checkpoint, then bind, then resume. A backtrack is always halt, then rollback, followed by a checkpoint or a further rollback.
- R4: A bind on a fresh level carries variable index equal to the number of variables already bound, node index equal to that variable modulo `N_NODES`, and value 0.
- R5: A `node_viol` pulse seen while propagating (with at least one variable bound) is answered with a halt command on the next cycle, and a rollback command on the cycle after that.
- R6: After a rollback, the same variable is re-bound with the value one above its previous attempt. If all `N_VALS` values of that level are spent, one more level is rolled back. If level 0 is spent, the search ends unsolvable.
- R7: When the network goes quiet with all `N_VARS` variables bound, `done` rises with `solved` = 1. Both hold until the next `start`.
- R8: When the network goes quiet with variables still unbound and any `node_full` bit set, the search ends unsolvable and issues no checkpoint.
- R9: While reset is asserted, no command is valid and `done` and `solved` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new search (accepted when idle or finished) |
| node_idle | input | N_NODES | Per-node propagation idle flag |
| upd_busy | input | 1 | A store update is still travelling between nodes |
| node_ack | input | N_NODES | Per-node barrier acknowledge pulse |
| node_viol | input | N_NODES | Per-node constraint violation pulse |
| node_full | input | N_NODES | Per-node configuration stack has no free slot |
| cmd_valid | output | 1 | Command bus carries an order this cycle |
| cmd_op | output | 3 | Opcode (0 checkpoint, 1 bind, 2 rollback, 3 halt, 4 resume) |
| cmd_node | output | clog2(N_NODES) | Bind target node, 0 otherwise |
| cmd_var | output | clog2(N_VARS) | Bind variable index, 0 otherwise |
| cmd_val | output | clog2(N_VALS) | Bind value, 0 otherwise |
| done | output | 1 | Search finished |
| solved | output | 1 | Verdict, valid while `done`: 1 solved, 0 unsolvable |

## Verification
A corrupted level counter or candidate slot shows up on the bus at the next bind. That bind carries the wrong variable, the wrong owner node or a skipped value, usually one labelling step after the fault. A broken barrier or quiet qualifier shows as a bind issued before the last acknowledge, or as a checkpoint issued straight after a one-cycle quiet glitch. Both are visible within a few cycles. A wrong rollback decision changes how many binds the search issues and which verdict it reaches, so it is caught when `done` rises. The bench compares that count and the verdict against a depth-first search it runs itself.

// File: rtl/sdc_pkg.sv
`timescale 1ns/1ps
package sdc_pkg;
  typedef enum logic [2:0] {
    OP_PUSH   = 3'd0,
    OP_BIND   = 3'd1,
    OP_POP    = 3'd2,
    OP_HALT   = 3'd3,
    OP_RESUME = 3'd4
  } sdc_op_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_PUSH, ST_PACK, ST_BIND,
    ST_RES,  ST_HALT, ST_POP,  ST_QACK, ST_DONE
  } sdc_state_e;
endpackage

// File: rtl/sdc_stall_qual.sv
`timescale 1ns/1ps
module sdc_stall_qual #(
  parameter int RUN_LEN = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm_i,
  input  logic quiet_i,
  output logic stall_o
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    if (!arm_i || !quiet_i)              cnt_d = '0;
    else if (cnt_q == CW'(RUN_LEN))      cnt_d = cnt_q;
    else                                 cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign stall_o = arm_i && (cnt_q == CW'(RUN_LEN));

  // R1
  quiet_before_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_o |-> $past(quiet_i));
endmodule

// File: rtl/sdc_ack_barrier.sv
`timescale 1ns/1ps
module sdc_ack_barrier #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic [N-1:0] ack_i,
  output logic         all_o
);
  logic [N-1:0] seen_q, seen_d;

  always_comb begin
    if (clr_i) seen_d = '0;
    else       seen_d = seen_q | ack_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen_q <= '0;
    else        seen_q <= seen_d;
  end

  assign all_o = &(seen_q | ack_i);
endmodule

// File: rtl/sdc_level_mem.sv
`timescale 1ns/1ps
module sdc_level_mem #(
  parameter int DEPTH = 3,
  parameter int W     = 3,
  parameter int IW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we_i,
  input  logic [IW-1:0] widx_i,
  input  logic [W-1:0]  wdata_i,
  input  logic [IW-1:0] ridx_i,
  output logic [W-1:0]  rdata_o
);
  logic [W-1:0] slot [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                             slot[i] <= '0;
      else if (we_i && (widx_i == IW'(i)))    slot[i] <= wdata_i;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int k = 0; k < DEPTH; k++)
      if (ridx_i == IW'(k)) rdata_o = slot[k];
  end
endmodule

// File: rtl/solver_dist_ctrl.sv
`timescale 1ns/1ps
module solver_dist_ctrl
  import sdc_pkg::*;
#(
  parameter int N_NODES = 4,
  parameter int N_VARS  = 3,
  parameter int N_VALS  = 4,
  localparam int NODE_W = (N_NODES > 1) ? $clog2(N_NODES) : 1,
  localparam int VAR_W  = (N_VARS  > 1) ? $clog2(N_VARS)  : 1,
  localparam int VAL_W  = (N_VALS  > 1) ? $clog2(N_VALS)  : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [N_NODES-1:0] node_idle,
  input  logic               upd_busy,
  input  logic [N_NODES-1:0] node_ack,
  input  logic [N_NODES-1:0] node_viol,
  input  logic [N_NODES-1:0] node_full,
  output logic               cmd_valid,
  output logic [2:0]         cmd_op,
  output logic [NODE_W-1:0]  cmd_node,
  output logic [VAR_W-1:0]   cmd_var,
  output logic [VAL_W-1:0]   cmd_val,
  output logic               done,
  output logic               solved
);
  localparam int DEP_W = $clog2(N_VARS + 1);
  localparam int CNT_W = $clog2(N_VALS + 1);

  sdc_state_e       state_q, state_d;
  logic [DEP_W-1:0] depth_q, depth_d;
  logic             solved_q, solved_d;
  logic             stall_q, acks_done;
  logic             mem_we;
  logic [CNT_W-1:0] mem_wdata, cand;
  logic [VAR_W-1:0] rd_idx;

  sdc_stall_qual #(.RUN_LEN(2)) u_stall (
    .clk(clk), .rst_n(rst_n),
    .arm_i(state_q == ST_WAIT),
    .quiet_i((&node_idle) && !upd_busy),
    .stall_o(stall_q)
  );

  sdc_ack_barrier #(.N(N_NODES)) u_barrier (
    .clk(clk), .rst_n(rst_n),
    .clr_i((state_q == ST_PUSH) || (state_q == ST_POP)),
    .ack_i(node_ack),
    .all_o(acks_done)
  );

  assign rd_idx = (state_q == ST_QACK) ? VAR_W'(depth_q - DEP_W'(1)) : VAR_W'(depth_q);

  sdc_level_mem #(.DEPTH(N_VARS), .W(CNT_W), .IW(VAR_W)) u_levels (
    .clk(clk), .rst_n(rst_n),
    .we_i(mem_we),
    .widx_i(VAR_W'(depth_q)),
    .wdata_i(mem_wdata),
    .ridx_i(rd_idx),
    .rdata_o(cand)
  );

  always_comb begin
    state_d   = state_q;
    depth_d   = depth_q;
    solved_d  = solved_q;
    mem_we    = 1'b0;
    mem_wdata = '0;
    unique case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start) begin
          state_d  = ST_WAIT;
          depth_d  = '0;
          solved_d = 1'b0;
        end
      end
      ST_WAIT: begin
        if (|node_viol) begin
          state_d = (depth_q == '0) ? ST_DONE : ST_HALT;
        end else if (stall_q) begin
          if (depth_q == DEP_W'(N_VARS)) begin
            state_d  = ST_DONE;
            solved_d = 1'b1;
          end else if (|node_full) begin
            state_d = ST_DONE;
          end else begin
            state_d = ST_PUSH;
            mem_we  = 1'b1;
          end
        end
      end
      ST_PUSH: state_d = ST_PACK;
      ST_PACK: if (acks_done) state_d = ST_BIND;
      ST_BIND: begin
        mem_we    = 1'b1;
        mem_wdata = cand + CNT_W'(1);
        depth_d   = depth_q + DEP_W'(1);
        state_d   = ST_RES;
      end
      ST_RES:  state_d = ST_WAIT;
      ST_HALT: state_d = ST_POP;
      ST_POP:  state_d = ST_QACK;
      ST_QACK: begin
        if (acks_done) begin
          depth_d = depth_q - DEP_W'(1);
          if (cand < CNT_W'(N_VALS))      state_d = ST_PUSH;
          else if (depth_q == DEP_W'(1))  state_d = ST_DONE;
          else                            state_d = ST_POP;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      depth_q  <= '0;
      solved_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      depth_q  <= depth_d;
      solved_q <= solved_d;
    end
  end

  always_comb begin
    cmd_valid = 1'b1;
    cmd_op    = OP_PUSH;
    cmd_node  = '0;
    cmd_var   = '0;
    cmd_val   = '0;
    case (state_q)
      ST_PUSH: cmd_op = OP_PUSH;
      ST_BIND: begin
        cmd_op   = OP_BIND;
        cmd_node = NODE_W'(32'(depth_q) % N_NODES);
        cmd_var  = VAR_W'(depth_q);
        cmd_val  = VAL_W'(cand);
      end
      ST_RES:  cmd_op = OP_RESUME;
      ST_HALT: cmd_op = OP_HALT;
      ST_POP:  cmd_op = OP_POP;
      default: cmd_valid = 1'b0;
    endcase
  end

  assign done   = (state_q == ST_DONE);
  assign solved = solved_q;

  // R2
  bind_after_barrier_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == OP_BIND) |-> $past(acks_done));

  // R5
  halt_on_viol_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && (|node_viol) && depth_q != '0) |=> (cmd_valid && cmd_op == OP_HALT));

  // R7
  verdict_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> (done && $stable(solved)));

  // R4
  depth_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    depth_q <= DEP_W'(N_VARS));
endmodule

// File: tb/solver_dist_ctrl_test.sv
`timescale 1ns/1ps
module solver_dist_ctrl_test;
  localparam int NN = 4;
  localparam int NV = 3;
  localparam int NQ = 4;
  localparam int OPC_PUSH = 0, OPC_BIND = 1, OPC_POP = 2, OPC_HALT = 3, OPC_RES = 4;

  logic          clk, rst_n, start, upd_busy;
  logic [NN-1:0] node_idle, node_ack, node_viol, node_full;
  logic          cmd_valid, done, solved;
  logic [2:0]    cmd_op;
  logic [1:0]    cmd_node, cmd_var, cmd_val;

  solver_dist_ctrl #(.N_NODES(NN), .N_VARS(NV), .N_VALS(NQ)) uut (
    .clk(clk), .rst_n(rst_n), .start(start),
    .node_idle(node_idle), .upd_busy(upd_busy),
    .node_ack(node_ack), .node_viol(node_viol), .node_full(node_full),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_node(cmd_node),
    .cmd_var(cmd_var), .cmd_val(cmd_val), .done(done), .solved(solved)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0, errors = 0;
  bit forb [NV][NQ];
  int cap;
  int asg [NV];
  int lastval [NV];
  int exp_asg [NV];
  int exp_binds;
  bit exp_solved;
  int sdepth, last_op, binds_seen, busy_cnt, ack_given, run_len, prev_run;
  int ack_dly [NN];
  bit fresh, bad_pending, barrier_open, exp_halt, exp_pop;

  task automatic chk(bit c, string req, int act, int expv, string what);
    checks++;
    if (!c) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit ok_part(int a [NV], int d);
    for (int i = 0; i < d; i++) begin
      if (forb[i][a[i]]) return 1'b0;
      if (i > 0 && a[i] == a[i-1]) return 1'b0;
    end
    return 1'b1;
  endfunction

  function automatic bit legal(int prev, int op);
    case (prev)
      -1:       return op == OPC_PUSH;
      OPC_PUSH: return op == OPC_BIND;
      OPC_BIND: return op == OPC_RES;
      OPC_RES:  return op == OPC_PUSH || op == OPC_HALT;
      OPC_HALT: return op == OPC_POP;
      OPC_POP:  return op == OPC_POP || op == OPC_PUSH;
      default:  return 1'b0;
    endcase
  endfunction

  task automatic dfs();
    int d;
    int nx [NV];
    int a [NV];
    d = 0;
    for (int i = 0; i < NV; i++) begin nx[i] = 0; a[i] = 0; end
    exp_binds = 0;
    exp_solved = 1'b0;
    if (cap > 0) begin
      for (int g = 0; g < 100000; g++) begin
        if (nx[d] >= NQ) begin
          if (d == 0) break;
          d--;
          continue;
        end
        a[d] = nx[d];
        nx[d]++;
        exp_binds++;
        if (ok_part(a, d + 1)) begin
          d++;
          if (d == NV) begin exp_solved = 1'b1; break; end
          if (d >= cap) break;
          nx[d] = 0;
        end
      end
    end
    for (int i = 0; i < NV; i++) exp_asg[i] = a[i];
  endtask

  task automatic drive_quiet();
    node_idle = '1;
    upd_busy  = 1'b0;
  endtask

  task automatic drive_busy();
    node_idle = NN'($urandom) & ~NN'(1);
    upd_busy  = 1'($urandom);
  endtask

  task automatic open_barrier();
    barrier_open = 1'b1;
    ack_given = 0;
    for (int n = 0; n < NN; n++) ack_dly[n] = 2 + int'($urandom % 4);
  endtask

  // Reactive model of the node network, evaluated once per falling edge.
  task automatic node_step();
    bit q;
    int op, v, ev;
    q = (&node_idle) && !upd_busy;
    prev_run = run_len;
    run_len = q ? run_len + 1 : 0;
    if (exp_halt) begin
      chk(cmd_valid && cmd_op == 3'(OPC_HALT), "R5", int'(cmd_op), OPC_HALT, "halt after violation");
      exp_halt = 1'b0;
    end else if (exp_pop) begin
      chk(cmd_valid && cmd_op == 3'(OPC_POP), "R5", int'(cmd_op), OPC_POP, "rollback after halt");
      exp_pop = 1'b0;
    end
    if (cmd_valid) begin
      op = int'(cmd_op);
      chk(legal(last_op, op), "R3", op, last_op, "opcode after previous opcode");
      case (op)
        OPC_PUSH: begin
          if (last_op != OPC_POP) begin
            chk(prev_run >= 2, "R1", prev_run, 2, "quiet run before checkpoint");
            fresh = 1'b1;
          end else begin
            fresh = 1'b0;
            chk(ack_given == NN, "R2", ack_given, NN, "acks before checkpoint");
          end
          open_barrier();
          sdepth++;
        end
        OPC_BIND: begin
          chk(barrier_open && ack_given == NN, "R2", ack_given, NN, "acks before bind");
          barrier_open = 1'b0;
          v = int'(cmd_var);
          chk(v == sdepth - 1, "R4", v, sdepth - 1, "bind variable");
          chk(int'(cmd_node) == v % NN, "R4", int'(cmd_node), v % NN, "bind node");
          ev = fresh ? 0 : lastval[v] + 1;
          if (fresh) chk(int'(cmd_val) == ev, "R4", int'(cmd_val), ev, "first value");
          else       chk(int'(cmd_val) == ev, "R6", int'(cmd_val), ev, "retry value");
          if (v >= 0 && v < NV) begin
            asg[v] = int'(cmd_val);
            lastval[v] = int'(cmd_val);
          end
          binds_seen++;
        end
        OPC_RES: begin
          busy_cnt = 2 + int'($urandom % 5);
          bad_pending = !ok_part(asg, sdepth);
        end
        OPC_HALT: exp_pop = 1'b1;
        OPC_POP: begin
          if (barrier_open) chk(ack_given == NN, "R2", ack_given, NN, "acks before rollback");
          open_barrier();
          sdepth--;
        end
        default: ;
      endcase
      last_op = op;
    end
    node_ack = '0;
    for (int n = 0; n < NN; n++) begin
      if (ack_dly[n] > 0) begin
        ack_dly[n]--;
        if (ack_dly[n] == 0) begin
          node_ack[n] = 1'b1;
          ack_given++;
        end
      end
    end
    node_viol = '0;
    if (busy_cnt > 0) begin
      busy_cnt--;
      if (busy_cnt == 0 && bad_pending) begin
        drive_busy();
        node_viol[$urandom % NN] = 1'b1;
        bad_pending = 1'b0;
        exp_halt = 1'b1;
      end else if (busy_cnt == 0) begin
        drive_quiet();
      end else if (!q && ($urandom % 2 == 1)) begin
        drive_quiet();
      end else begin
        drive_busy();
      end
    end else begin
      drive_quiet();
    end
    node_full = (sdepth >= cap) ? (NN'(1) << (sdepth % NN)) : '0;
  endtask

  task automatic tick();
    @(negedge clk);
    node_step();
  endtask

  task automatic run_case(int c);
    int waitc;
    string rq;
    cap = c;
    dfs();
    rq = (cap < NV) ? "R8" : "R7";
    sdepth = 0; last_op = -1; binds_seen = 0; busy_cnt = 0; ack_given = 0;
    fresh = 0; bad_pending = 0; barrier_open = 0; exp_halt = 0; exp_pop = 0;
    for (int i = 0; i < NV; i++) begin asg[i] = 0; lastval[i] = 0; end
    for (int n = 0; n < NN; n++) ack_dly[n] = 0;
    start = 1'b1;
    tick();
    start = 1'b0;
    waitc = 0;
    while (!done && waitc < 6000) begin
      tick();
      waitc++;
    end
    chk(done, rq, int'(done), 1, "search finished");
    chk(solved == exp_solved, rq, int'(solved), int'(exp_solved), "verdict");
    chk(binds_seen == exp_binds, "R6", binds_seen, exp_binds, "bind count");
    chk(last_op == -1 || last_op == OPC_RES || last_op == OPC_POP, "R3", last_op, OPC_RES, "last order before finish");
    if (barrier_open) chk(ack_given == NN, "R2", ack_given, NN, "acks before finish");
    if (c == 0) chk(binds_seen == 0, "R8", binds_seen, 0, "no step with full stack");
    if (exp_solved)
      for (int i = 0; i < NV; i++)
        chk(asg[i] == exp_asg[i], "R7", asg[i], exp_asg[i], "solution value");
    repeat (3) tick();
    chk(done && solved == exp_solved, "R7", int'(solved), int'(exp_solved), "verdict held");
  endtask

  task automatic set_forb(int pct);
    for (int i = 0; i < NV; i++)
      for (int j = 0; j < NQ; j++)
        forb[i][j] = ($urandom % 100) < pct;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL R7 watchdog: actual %0d expected %0d", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd20240));
    run_len = 0; prev_run = 0; cap = 99; sdepth = 0;
    start = 1'b0; upd_busy = 1'b0; node_idle = '1;
    node_ack = '0; node_viol = '0; node_full = '0;
    for (int n = 0; n < NN; n++) ack_dly[n] = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(!cmd_valid, "R9", int'(cmd_valid), 0, "no command in reset");
    chk(!done && !solved, "R9", int'(done), 0, "no verdict in reset");
    rst_n = 1'b1;
    tick();
    // R7: unconstrained problem, first solution 0,1,0
    set_forb(0);
    run_case(99);
    // R6: every value of variable 0 rejected
    set_forb(0);
    for (int j = 0; j < NQ; j++) forb[0][j] = 1'b1;
    run_case(99);
    // R6: deepest variable always rejected, full search exhausted
    set_forb(0);
    for (int j = 0; j < NQ; j++) forb[2][j] = 1'b1;
    run_case(99);
    // R8: stack full before any step, and after two levels
    set_forb(0);
    run_case(0);
    run_case(2);
    for (int r = 0; r < 24; r++) begin
      set_forb(25 + int'($urandom % 30));
      run_case(($urandom % 5 == 0) ? int'($urandom % NV) : 99);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule